// File: doc/BRIEF.md
# Segmented Multi-Ring Transfer Arbiter

This block is the central scheduler for a small set of unidirectional data rings that link a fixed number of bus ports. A port that wants to move data raises a request naming the destination port; the arbiter picks a ring direction, finds a ring of that direction whose hop segments along the path are all free, and grants the request. Because rings are reserved per segment rather than as a whole, several transfers with disjoint paths run side by side on one ring, up to a fixed cap of concurrent transfers per ring.

Ports never learn which ring carries their data: they see only a grant or an error pulse. A granted port keeps its outgoing slot until it pulses its release line, which returns the path segments and the ring's transfer count to the pool. Requests are considered one per cycle in round-robin order across ports. The data path and per-port flow control sit outside this block.

Top module: `ring_bus_arbiter`

## Requirements
- R1: After reset no grant or error is pending, every port's outgoing slot is free and every ring segment is free; a reset during activity discards all held transfers.
- R2: A request sampled at a clock edge produces its grant or error pulse on the outputs right after that edge; across all ports at most one grant or error is asserted per cycle, and a grant only follows a request from that port.
- R3: Rings 0 to NRINGS/2-1 run clockwise (port i toward port i+1 mod NPORTS), the rest counter-clockwise; a request uses the direction with fewer hops, and when both hop counts are equal it uses clockwise.
- R4: Segment k joins port k and port k+1 mod NPORTS; a clockwise transfer of d hops from port s occupies segments s to s+d-1 (mod NPORTS), a counter-clockwise one occupies the same segments as the clockwise path from destination to source. A grant is given only on a ring where none of those segments is held by an active transfer, and transfers with disjoint segments may share a ring.
- R5: If the first ring of the chosen direction cannot take the transfer, the other rings of that direction are tried in ascending index; if none fits, no grant is given and the request is retried while it stays raised.
- R6: No ring ever carries more than MAX_ACTIVE transfers; a ring at the cap accepts no new transfer even when its segments are free.
- R7: Among ports with a raised request and a free slot, the one considered each cycle is the first at or after a rotating pointer; the pointer moves to the port after the one considered, so simultaneous requests are served in cyclic port order.
- R8: A request whose destination equals its source, or whose destination index is NPORTS or above, gets an error pulse instead of a grant and takes no slot or segment; the port may request again at once.
- R9: A port holding a granted transfer has its requests ignored; its release pulse frees its segments, its ring count and its slot at that edge, so a waiting request can be granted on the next one.
- R10: A release pulse from a port that holds no transfer changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NPORTS | Per-port transfer request, held until grant or error |
| req_dst | input | NPORTS*PW | Per-port destination index, PW bits per port, port p at bits p*PW upward |
| rel | input | NPORTS | Per-port release pulse ending that port's transfer |
| gnt | output | NPORTS | Registered one-cycle grant pulse per port |
| err | output | NPORTS | Registered one-cycle error pulse per port |

## Verification
The bench builds the arbiter with its defaults: 12 ports, four rings (two per direction) and a cap of three transfers per ring. With only two rings per direction, a few short transfers are enough to fill both clockwise rings on one segment or to push both to the cap, which makes the second-ring fallback, the cap and the direction choice observable purely through granted versus withheld requests. An even port count makes the six-hop tie reachable, and the 4-bit destination field allows out-of-range indices 12 to 15 to be driven.

// File: rtl/ring_arb_pkg.sv
package ring_arb_pkg;
  typedef enum logic {
    RING_CW  = 1'b0,
    RING_CCW = 1'b1
  } ring_dir_e;
endpackage

// File: rtl/ring_path_calc.sv
module ring_path_calc
  import ring_arb_pkg::*;
#(
  parameter int NPORTS = 12,
  localparam int PW = $clog2(NPORTS)
) (
  input  logic [PW-1:0]     src,
  input  logic [PW-1:0]     dst,
  output logic              bad,
  output ring_dir_e         dir,
  output logic [NPORTS-1:0] seg_mask
);
  always_comb begin
    int s;
    int t;
    int d;
    int start;
    int len;
    int off;
    s   = int'(src);
    t   = int'(dst);
    bad = (t >= NPORTS) || (s == t);
    d   = bad ? 0 : (t - s + NPORTS) % NPORTS;
    if (2 * d <= NPORTS) begin
      dir   = RING_CW;
      start = s;
      len   = d;
    end else begin
      dir   = RING_CCW;
      start = t;
      len   = NPORTS - d;
    end
    for (int i = 0; i < NPORTS; i++) begin
      off = (i - start + NPORTS) % NPORTS;
      seg_mask[i] = !bad && (off < len);
    end
  end
endmodule

// File: rtl/ring_select.sv
module ring_select
  import ring_arb_pkg::*;
#(
  parameter int NPORTS     = 12,
  parameter int NRINGS     = 4,
  parameter int MAX_ACTIVE = 3,
  localparam int CW_W = $clog2(MAX_ACTIVE + 1),
  localparam int RW   = (NRINGS > 1) ? $clog2(NRINGS) : 1
) (
  input  logic [NRINGS*NPORTS-1:0] occ_flat,
  input  logic [NRINGS*CW_W-1:0]   cnt_flat,
  input  ring_dir_e                dir,
  input  logic [NPORTS-1:0]        seg_mask,
  output logic                     hit,
  output logic [RW-1:0]            sel
);
  logic [NRINGS-1:0] fit;

  for (genvar r = 0; r < NRINGS; r++) begin : g_ring
    localparam ring_dir_e RDIR = (r < NRINGS / 2) ? RING_CW : RING_CCW;
    assign fit[r] = (dir == RDIR)
                 && ((occ_flat[r*NPORTS +: NPORTS] & seg_mask) == '0)
                 && (cnt_flat[r*CW_W +: CW_W] < CW_W'(MAX_ACTIVE));
  end

  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int r = NRINGS - 1; r >= 0; r--) begin
      if (fit[r]) begin
        hit = 1'b1;
        sel = RW'(r);
      end
    end
  end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int NPORTS = 12,
  localparam int PW = $clog2(NPORTS)
) (
  input  logic [NPORTS-1:0] cand,
  input  logic [PW-1:0]     ptr,
  output logic              found,
  output logic [PW-1:0]     idx
);
  always_comb begin
    int j;
    found = 1'b0;
    idx   = '0;
    for (int k = NPORTS - 1; k >= 0; k--) begin
      j = (int'(ptr) + k) % NPORTS;
      if (cand[j]) begin
        found = 1'b1;
        idx   = PW'(j);
      end
    end
  end
endmodule

// File: rtl/ring_bus_arbiter.sv
module ring_bus_arbiter
  import ring_arb_pkg::*;
#(
  parameter int NPORTS     = 12,
  parameter int NRINGS     = 4,
  parameter int MAX_ACTIVE = 3,
  localparam int PW   = $clog2(NPORTS),
  localparam int CW_W = $clog2(MAX_ACTIVE + 1),
  localparam int RW   = (NRINGS > 1) ? $clog2(NRINGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPORTS-1:0]    req_valid,
  input  logic [NPORTS*PW-1:0] req_dst,
  input  logic [NPORTS-1:0]    rel,
  output logic [NPORTS-1:0]    gnt,
  output logic [NPORTS-1:0]    err
);
  // Per-ring segment occupancy and live transfer count
  logic [NPORTS-1:0] occ     [NRINGS];
  logic [NPORTS-1:0] occ_n   [NRINGS];
  logic [CW_W-1:0]   cnt     [NRINGS];
  logic [CW_W-1:0]   cnt_n   [NRINGS];
  logic [NRINGS*NPORTS-1:0] occ_flat;
  logic [NRINGS*CW_W-1:0]   cnt_flat;

  // Per-port record of the held transfer
  logic [NPORTS-1:0] held;
  logic [RW-1:0]     port_ring [NPORTS];
  logic [NPORTS-1:0] port_mask [NPORTS];

  logic [PW-1:0]     rr_ptr;
  logic [NPORTS-1:0] gnt_q, err_q;

  logic [NPORTS-1:0] cand, rel_eff, pick_oh;
  logic              found, bad, hit, do_grant, do_err;
  logic [PW-1:0]     pick, pick_dst;
  ring_dir_e         dir;
  logic [NPORTS-1:0] seg_mask;
  logic [RW-1:0]     sel;

  assign cand     = req_valid & ~held;
  assign rel_eff  = rel & held;
  assign pick_dst = req_dst[int'(pick)*PW +: PW];

  for (genvar r = 0; r < NRINGS; r++) begin : g_flat
    assign occ_flat[r*NPORTS +: NPORTS] = occ[r];
    assign cnt_flat[r*CW_W +: CW_W]     = cnt[r];
  end

  rr_pick #(.NPORTS(NPORTS)) u_pick (
    .cand (cand),
    .ptr  (rr_ptr),
    .found(found),
    .idx  (pick)
  );

  ring_path_calc #(.NPORTS(NPORTS)) u_path (
    .src     (pick),
    .dst     (pick_dst),
    .bad     (bad),
    .dir     (dir),
    .seg_mask(seg_mask)
  );

  ring_select #(
    .NPORTS    (NPORTS),
    .NRINGS    (NRINGS),
    .MAX_ACTIVE(MAX_ACTIVE)
  ) u_sel (
    .occ_flat(occ_flat),
    .cnt_flat(cnt_flat),
    .dir     (dir),
    .seg_mask(seg_mask),
    .hit     (hit),
    .sel     (sel)
  );

  assign do_grant = found && !bad && hit;
  assign do_err   = found && bad;
  assign pick_oh  = {{(NPORTS-1){1'b0}}, 1'b1} << pick;

  // Releases and the new grant never touch the same segments
  always_comb begin
    for (int r = 0; r < NRINGS; r++) begin
      occ_n[r] = occ[r];
      cnt_n[r] = cnt[r];
    end
    for (int p = 0; p < NPORTS; p++) begin
      if (rel_eff[p]) begin
        occ_n[port_ring[p]] = occ_n[port_ring[p]] & ~port_mask[p];
        cnt_n[port_ring[p]] = cnt_n[port_ring[p]] - CW_W'(1);
      end
    end
    if (do_grant) begin
      occ_n[sel] = occ_n[sel] | seg_mask;
      cnt_n[sel] = cnt_n[sel] + CW_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held   <= '0;
      rr_ptr <= '0;
      gnt_q  <= '0;
      err_q  <= '0;
      for (int r = 0; r < NRINGS; r++) begin
        occ[r] <= '0;
        cnt[r] <= '0;
      end
      for (int p = 0; p < NPORTS; p++) begin
        port_ring[p] <= '0;
        port_mask[p] <= '0;
      end
    end else begin
      for (int r = 0; r < NRINGS; r++) begin
        occ[r] <= occ_n[r];
        cnt[r] <= cnt_n[r];
      end
      held  <= (held & ~rel_eff) | (do_grant ? pick_oh : '0);
      gnt_q <= do_grant ? pick_oh : '0;
      err_q <= do_err   ? pick_oh : '0;
      if (do_grant) begin
        port_ring[pick] <= sel;
        port_mask[pick] <= seg_mask;
      end
      if (found) begin
        rr_ptr <= (pick == PW'(NPORTS - 1)) ? '0 : pick + PW'(1);
      end
    end
  end

  assign gnt = gnt_q;
  assign err = err_q;

  // ---------------- assertions ----------------
  p_one_event_r2: assert property (@(posedge clk) disable iff (rst)
    $countones({gnt_q, err_q}) <= 1);

  for (genvar p = 0; p < NPORTS; p++) begin : g_port_chk
    p_grant_has_req_r2: assert property (@(posedge clk) disable iff (rst)
      gnt_q[p] |-> $past(req_valid[p]));
    p_no_regrant_r9: assert property (@(posedge clk) disable iff (rst)
      gnt_q[p] |-> !$past(held[p]));
    p_err_no_slot_r8: assert property (@(posedge clk) disable iff (rst)
      err_q[p] |-> !held[p]);
  end

  for (genvar r = 0; r < NRINGS; r++) begin : g_ring_chk
    logic [PW:0] tally;
    always_comb begin
      tally = '0;
      for (int p = 0; p < NPORTS; p++) begin
        if (held[p] && port_ring[p] == RW'(r)) tally = tally + 1'b1;
      end
    end
    p_cap_r6: assert property (@(posedge clk) disable iff (rst)
      int'(cnt[r]) <= MAX_ACTIVE);
    p_count_match_r6: assert property (@(posedge clk) disable iff (rst)
      int'(cnt[r]) == int'(tally));
  end

  logic seg_clash;
  always_comb begin
    seg_clash = 1'b0;
    for (int a = 0; a < NPORTS; a++) begin
      for (int b = a + 1; b < NPORTS; b++) begin
        if (held[a] && held[b] && port_ring[a] == port_ring[b]
            && (port_mask[a] & port_mask[b]) != '0) seg_clash = 1'b1;
      end
    end
  end
  p_disjoint_r4: assert property (@(posedge clk) disable iff (rst) !seg_clash);
endmodule

// File: tb/ring_bus_arbiter_tb.sv
`timescale 1ns/1ps
module ring_bus_arbiter_tb;
  localparam int N  = 12;
  localparam int PW = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    req_valid = '0;
  logic [N*PW-1:0] req_dst = '0;
  logic [N-1:0]    rel = '0;
  logic [N-1:0]    gnt, err;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  ring_bus_arbiter u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_dst(req_dst),
    .rel(rel), .gnt(gnt), .err(err)
  );

  // Entry: {op(2) 0=request 1=release, port(4), dst(4), expect(2) 0=none 1=grant 2=error, tag(4)}
  localparam int NV = 21;
  localparam logic [15:0] VEC [NV] = '{
    {2'd0, 4'd11, 4'd1,  2'd1, 4'd4},  // R4 cw 2 hops, ring 0
    {2'd0, 4'd10, 4'd1,  2'd1, 4'd5},  // R5 overlaps ring 0, lands on ring 1
    {2'd0, 4'd0,  4'd3,  2'd0, 4'd3},  // R3 cw path blocked on both cw rings
    {2'd0, 4'd3,  4'd0,  2'd1, 4'd3},  // R3 nine cw hops -> ccw, free ring
    {2'd0, 4'd0,  4'd6,  2'd0, 4'd3},  // R3 tie goes cw, which is blocked
    {2'd0, 4'd5,  4'd5,  2'd2, 4'd8},  // R8 self transfer
    {2'd0, 4'd2,  4'd3,  2'd1, 4'd4},  // R4 shares ring 0
    {2'd0, 4'd4,  4'd5,  2'd1, 4'd4},  // R4 ring 0 now at three
    {2'd0, 4'd6,  4'd7,  2'd1, 4'd6},  // R6 ring 0 full, ring 1 takes it
    {2'd0, 4'd8,  4'd9,  2'd1, 4'd6},  // R6 ring 1 now at three
    {2'd0, 4'd7,  4'd8,  2'd0, 4'd6},  // R6 free segment but both cw rings full
    {2'd0, 4'd11, 4'd5,  2'd0, 4'd9},  // R9 held port ignored
    {2'd1, 4'd7,  4'd0,  2'd0, 4'd10}, // R10 release from idle port
    {2'd0, 4'd7,  4'd8,  2'd0, 4'd10}, // R10 still blocked
    {2'd1, 4'd11, 4'd0,  2'd0, 4'd9},  // R9 release frees ring 0 slot
    {2'd0, 4'd7,  4'd8,  2'd1, 4'd9},  // R9 now granted
    {2'd0, 4'd0,  4'd3,  2'd0, 4'd4},  // R4 segment 2 busy, ring 1 full
    {2'd1, 4'd2,  4'd0,  2'd0, 4'd9},  // R9 release segment 2
    {2'd0, 4'd0,  4'd3,  2'd1, 4'd4},  // R4 granted
    {2'd0, 4'd1,  4'd13, 2'd2, 4'd8},  // R8 destination out of range
    {2'd0, 4'd1,  4'd11, 2'd1, 4'd8}   // R8 port free after error, ccw ring 3
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int tag,
                       input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic set_dst(input int p, input int d);
    req_dst[p*PW +: PW] = PW'(d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int rr_a [3] = '{2, 5, 9};
    int rr_b [3] = '{11, 1, 4};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({8'd0, err, gnt}, 32'd0, 1, "R1 idle after reset");

    // Vector walk
    for (int v = 0; v < NV; v++) begin
      logic [1:0] op, ex;
      int port, dst, tag;
      logic [N-1:0] eg, ee;
      op   = VEC[v][15:14];
      port = int'(VEC[v][13:10]);
      dst  = int'(VEC[v][9:6]);
      ex   = VEC[v][5:4];
      tag  = int'(VEC[v][3:0]);
      eg   = (ex == 2'd1) ? (N'(1) << port) : '0;
      ee   = (ex == 2'd2) ? (N'(1) << port) : '0;
      @(negedge clk);
      if (op == 2'd0) begin
        set_dst(port, dst);
        req_valid[port] = 1'b1;
      end else begin
        rel[port] = 1'b1;
      end
      @(negedge clk);
      req_valid = '0;
      rel = '0;
      check({8'd0, err, gnt}, {8'd0, ee, eg}, tag, $sformatf("vector %0d", v));
    end

    // R1 reset during activity, then R7 round-robin order
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      set_dst(rr_a[i], rr_a[i] + 1);
      req_valid[rr_a[i]] = 1'b1;
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check({20'd0, gnt}, {20'd0, N'(1) << rr_a[i]}, 7, "R7 first round order");
      req_valid[rr_a[i]] = 1'b0;
    end
    for (int i = 0; i < 3; i++) rel[rr_a[i]] = 1'b1;
    @(negedge clk);
    rel = '0;
    set_dst(11, 0);
    set_dst(1, 2);
    set_dst(4, 5);
    for (int i = 0; i < 3; i++) req_valid[rr_b[i]] = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check({20'd0, gnt}, {20'd0, N'(1) << rr_b[i]}, 7, "R7 wrapped order");
      req_valid[rr_b[i]] = 1'b0;
    end

    // R1 port 10 held before reset must be free now (tie path, ring 1)
    @(negedge clk);
    set_dst(10, 4);
    req_valid[10] = 1'b1;
    @(negedge clk);
    req_valid = '0;
    check({8'd0, err, gnt}, {20'd0, N'(1) << 10}, 1, "R1 slot freed by reset");

    // R2 no output without request
    repeat (2) @(negedge clk);
    check({8'd0, err, gnt}, 32'd0, 2, "R2 quiet when idle");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule